// File: doc/BRIEF.md
# Two-Queue I2C Command Sequencer

This block runs stored command programs for one I2C controller. Software loads 32-bit command words into one of two queues, then starts a queue with a one-hot strobe and a word count for the run. The sequencer walks through the queue and decodes each word's opcode. It drives a byte-level bus engine with START, WRITE-byte, READ-byte and STOP requests, and it reacts to each acknowledge reply from that engine.

A command can set the target address, write a payload, read a number of bytes, or raise a report event. A write command keeps its payload in the same queue as itself: the bytes follow the command byte and continue into the next words. Read bytes are packed least-significant byte first into 32-bit words in a small read buffer. The first byte of a read's data is the address byte that went out on the bus, so a read of `len` bytes leaves `len/4 + 1` words. When a run ends, the queue's word count returns to zero. A not-acknowledge ends the run early with a stop and an error pulse. Bit-level bus timing and the bus pins belong to the byte engine, not to this block.

Three interfaces use valid/ready handshakes. On the load port a word transfers when `ld_valid` and `ld_ready` are both high. `ld_ready` is low only for the queue that is executing. On the byte-engine request port the request stays stable until `be_req_ready` is high, and the block waits for exactly one response pulse per accepted request. On the read port a word leaves when `rd_valid` and `rd_ready` are both high. The consumer must drain the read buffer before it fills; a word pushed into a full buffer is lost.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset both queue counts, `rd_level`, `busy`, `be_req_valid`, `q_ovf` and all event pulses are zero, and `ld_ready` is high.
- R2: Each load handshake appends `ld_word` to queue `ld_queue` (0 or 1) and raises that queue's count by one. `ld_ready` is low while `ld_queue` names the executing queue and high otherwise.
- R3: A load into a full queue (64 words for queue 0, 16 for queue 1) is dropped, the count stays the same, and that queue's `q_ovf` bit is set. The bit stays set until that queue is next started.
- R4: When idle, `start` equal to 2'b01 or 2'b10 runs queue 0 or queue 1 over words 0 to `exec_len`-1. Any start while busy, and `start` equal to 2'b11, is ignored.
- R5: A word with bits 3:0 = 1 sets the 7-bit target address from bits 10:4. Every START request carries `{address, rw}`, with rw 0 for a write and 1 for a read.
- R6: A word with bits 3:0 = 9 is a write of N bytes, where N is in bits 7:4. The requests are START, then N WRITE requests, then STOP. The payload begins in byte lane 1 of the command word and continues little-endian through the following words. The next command is the word after the last payload byte.
- R7: A word with bits 3:0 = 10 is a read of N bytes, where N is in bits 7:4. The requests are START, then N READ requests with `be_rd_last` high only on the final one, then STOP. `ev_rd_done` pulses once after the STOP reply.
- R8: The read buffer takes the START address byte and then each read byte, least-significant lane first. It closes a partial final word with zero upper lanes, so a read of N bytes adds N/4+1 words.
- R9: A word with bits 3:0 = 8 pulses `ev_report[q]` if bit 8 is set and does nothing otherwise. Words with any other opcode are skipped with no bus request.
- R10: When a run ends, the executed queue's count is zero and `busy` falls.
- R11: A nack reply to a START or WRITE request issues one STOP, pulses `ev_nack[q]`, and ends the run with no further words executed. The queue's count is cleared.
- R12: While `be_req_valid` is high and `be_req_ready` is low, the request and its `be_op` and `be_wdata` stay unchanged. `be_op` encodes 0 as START, 1 as WRITE, 2 as READ and 3 as STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load word valid |
| ld_ready | output | 1 | Load word accepted |
| ld_queue | input | 1 | Target queue of the load |
| ld_word | input | 32 | Command word to append |
| start | input | 2 | One-hot queue start strobe |
| exec_len | input | CW (7) | Number of words to execute, sampled at start |
| busy | output | 1 | A queue is executing |
| q0_count | output | CW (7) | Current word count of queue 0 |
| q1_count | output | CW (7) | Current word count of queue 1 |
| q_ovf | output | 2 | Per-queue sticky overflow flags |
| be_req_valid | output | 1 | Byte-engine request valid |
| be_req_ready | input | 1 | Byte-engine request accepted |
| be_op | output | 2 | Request kind: 0 START, 1 WRITE, 2 READ, 3 STOP |
| be_wdata | output | 8 | Address byte for START, data byte for WRITE |
| be_rd_last | output | 1 | Final byte of a read (controller nacks it) |
| be_rsp_valid | input | 1 | Byte-engine reply pulse |
| be_rsp_nack | input | 1 | Reply carried a not-acknowledge |
| be_rsp_data | input | 8 | Byte received on a READ reply |
| rd_valid | output | 1 | Read buffer holds a word |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | 32 | Oldest read buffer word |
| rd_level | output | RLW (3) | Words held in the read buffer |
| ev_report | output | 2 | Per-queue report pulse |
| ev_rd_done | output | 1 | Read command finished pulse |
| ev_nack | output | 2 | Per-queue nack error pulse |

## Verification
The assertions assume a byte engine that gives exactly one reply for each accepted request and never replies unasked. They also assume that `exec_len` never exceeds the loaded count, and that the read consumer keeps the buffer from overflowing. The bench's responder model replies only a fixed number of cycles after a handshake it saw, and holds `be_req_ready` low while a reply is pending. Each scenario starts a queue only with the count it loaded. Every read program is kept within the buffer's four words, and the buffer is drained before the next run.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;
  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_WRITE = 2'd1,
    BOP_READ  = 2'd2,
    BOP_STOP  = 2'd3
  } bop_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_REQ, S_WAIT, S_DONE
  } seq_state_e;

  localparam logic [3:0] OPC_PARAM  = 4'd1;
  localparam logic [3:0] OPC_REPORT = 4'd8;
  localparam logic [3:0] OPC_WRITE  = 4'd9;
  localparam logic [3:0] OPC_READ   = 4'd10;
  localparam int         REPORT_EN_BIT = 8;
endpackage

// File: rtl/i2c_cmd_seq_cmdq.sv
module i2c_cmd_seq_cmdq #(
  parameter int DEPTH = 16,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          clr,
  input  logic          ovf_clr,
  input  logic [CW-1:0] rd_idx,
  output logic [31:0]   rd_word,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0] mem [DEPTH];
  logic        full;
  logic        unused_idx_hi;

  assign full          = (count == CW'(DEPTH));
  assign rd_word       = mem[rd_idx[AW-1:0]];
  assign unused_idx_hi = ^rd_idx[CW-1:AW];

  always_ff @(posedge clk) begin
    if (wr_en && !full && !clr) mem[count[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (clr)              count <= '0;
      else if (wr_en && !full) count <= count + 1'b1;
      if (ovf_clr)          ovf <= 1'b0;
      else if (wr_en && full) ovf <= 1'b1;
    end
  end

  AST_Q_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_Q_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clr && !ovf_clr) |=> (count == CW'(DEPTH)) && ovf); // R3
  AST_Q_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R10
endmodule

// File: rtl/i2c_cmd_seq_rdbuf.sv
module i2c_cmd_seq_rdbuf #(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_byte,
  input  logic [7:0]    byte_in,
  input  logic          flush,
  input  logic          pop,
  output logic [31:0]   word_out,
  output logic [LW-1:0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [23:0]   acc;
  logic [1:0]    nb;
  logic [AW-1:0] wp, rp;
  logic          wpush, do_push, do_pop;
  logic [31:0]   wword;

  always_comb begin
    wpush   = (push_byte && nb == 2'd3) || (flush && nb != 2'd0);
    wword   = push_byte ? {byte_in, acc} : {8'h00, acc};
    do_push = wpush && (level != LW'(DEPTH));
    do_pop  = pop && (level != '0);
  end

  assign word_out = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wword;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; nb <= '0; wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (flush || (push_byte && nb == 2'd3)) begin
        acc <= '0;
        nb  <= '0;
      end else if (push_byte) begin
        case (nb)
          2'd0:    acc[7:0]   <= byte_in;
          2'd1:    acc[15:8]  <= byte_in;
          default: acc[23:16] <= byte_in;
        endcase
        nb <= nb + 2'd1;
      end
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_RB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wpush |-> (level != LW'(DEPTH))); // R8
  AST_RB_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R8
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_cmd_seq_pkg::*;
#(
  parameter  int Q0_DEPTH = 64,
  parameter  int Q1_DEPTH = 16,
  parameter  int RB_DEPTH = 4,
  localparam int CW  = $clog2(((Q0_DEPTH > Q1_DEPTH) ? Q0_DEPTH : Q1_DEPTH) + 1),
  localparam int RLW = $clog2(RB_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  output logic           ld_ready,
  input  logic           ld_queue,
  input  logic [31:0]    ld_word,
  input  logic [1:0]     start,
  input  logic [CW-1:0]  exec_len,
  output logic           busy,
  output logic [CW-1:0]  q0_count,
  output logic [CW-1:0]  q1_count,
  output logic [1:0]     q_ovf,
  output logic           be_req_valid,
  input  logic           be_req_ready,
  output logic [1:0]     be_op,
  output logic [7:0]     be_wdata,
  output logic           be_rd_last,
  input  logic           be_rsp_valid,
  input  logic           be_rsp_nack,
  input  logic [7:0]     be_rsp_data,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [31:0]    rd_data,
  output logic [RLW-1:0] rd_level,
  output logic [1:0]     ev_report,
  output logic           ev_rd_done,
  output logic [1:0]     ev_nack
);
  localparam int NQ = 2;

  seq_state_e    state;
  bop_e          cur_op;
  logic          act_q, rd_mode, abort_f;
  logic [CW-1:0] ptr, end_cnt;
  logic [6:0]    addr7;
  logic [3:0]    remain, next_remain;
  logic [1:0]    lane;
  logic [31:0]   q_word [NQ];
  logic [CW-1:0] q_cnt  [NQ];
  logic [31:0]   qword;
  logic          start_ok, ld_fire, rsp_ok, push_byte, flush;

  assign busy     = (state != S_IDLE);
  assign ld_ready = !(busy && (act_q == ld_queue));
  assign ld_fire  = ld_valid && ld_ready;
  assign start_ok = (state == S_IDLE) && (start == 2'b01 || start == 2'b10);
  assign qword    = q_word[act_q];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    localparam int DEP = (g == 0) ? Q0_DEPTH : Q1_DEPTH;
    i2c_cmd_seq_cmdq #(.DEPTH(DEP), .CW(CW)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ld_fire && (ld_queue == 1'(g))),
      .wr_data (ld_word),
      .clr     ((state == S_DONE) && (act_q == 1'(g))),
      .ovf_clr (start_ok && start[g]),
      .rd_idx  (ptr),
      .rd_word (q_word[g]),
      .count   (q_cnt[g]),
      .ovf     (q_ovf[g])
    );
  end

  assign q0_count = q_cnt[0];
  assign q1_count = q_cnt[1];

  assign be_req_valid = (state == S_REQ);
  assign be_op        = cur_op;
  assign be_rd_last   = (cur_op == BOP_READ) && (remain == 4'd1);
  always_comb begin
    case (cur_op)
      BOP_START: be_wdata = {addr7, rd_mode};
      BOP_WRITE: be_wdata = qword[{lane, 3'b000} +: 8];
      default:   be_wdata = 8'h00;
    endcase
  end

  assign rsp_ok      = (state == S_WAIT) && be_rsp_valid;
  assign next_remain = (cur_op == BOP_START) ? remain : remain - 4'd1;
  assign push_byte   = rsp_ok && rd_mode && !abort_f &&
                       ((cur_op == BOP_START && !be_rsp_nack) || cur_op == BOP_READ);
  assign flush       = rsp_ok && rd_mode && !abort_f && (cur_op == BOP_STOP);

  i2c_cmd_seq_rdbuf #(.DEPTH(RB_DEPTH), .LW(RLW)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_byte (push_byte),
    .byte_in   ((cur_op == BOP_START) ? {addr7, 1'b1} : be_rsp_data),
    .flush     (flush),
    .pop       (rd_valid && rd_ready),
    .word_out  (rd_data),
    .level     (rd_level)
  );
  assign rd_valid = (rd_level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cur_op <= BOP_START; act_q <= 1'b0; rd_mode <= 1'b0;
      abort_f <= 1'b0; ptr <= '0; end_cnt <= '0; addr7 <= '0; remain <= '0;
      lane <= '0; ev_report <= '0; ev_rd_done <= 1'b0; ev_nack <= '0;
    end else begin
      ev_report  <= '0;
      ev_rd_done <= 1'b0;
      ev_nack    <= '0;
      case (state)
        S_IDLE: if (start_ok) begin
          act_q   <= start[1];
          ptr     <= '0;
          end_cnt <= exec_len;
          abort_f <= 1'b0;
          state   <= S_FETCH;
        end
        S_FETCH: begin
          if (ptr == end_cnt) state <= S_DONE;
          else begin
            case (qword[3:0])
              OPC_PARAM: begin addr7 <= qword[10:4]; ptr <= ptr + 1'b1; end
              OPC_REPORT: begin
                if (qword[REPORT_EN_BIT]) ev_report[act_q] <= 1'b1;
                ptr <= ptr + 1'b1;
              end
              OPC_WRITE: begin
                remain <= qword[7:4]; lane <= 2'd1; rd_mode <= 1'b0;
                cur_op <= BOP_START; state <= S_REQ;
              end
              OPC_READ: begin
                remain <= qword[7:4]; rd_mode <= 1'b1; ptr <= ptr + 1'b1;
                cur_op <= BOP_START; state <= S_REQ;
              end
              default: ptr <= ptr + 1'b1;
            endcase
          end
        end
        S_REQ: if (be_req_ready) state <= S_WAIT;
        S_WAIT: if (be_rsp_valid) begin
          if (cur_op == BOP_STOP) begin
            if (abort_f) begin
              ev_nack[act_q] <= 1'b1;
              state <= S_DONE;
            end else begin
              if (rd_mode) ev_rd_done <= 1'b1;
              else if (lane != 2'd0) ptr <= ptr + 1'b1;
              state <= S_FETCH;
            end
          end else if (be_rsp_nack && cur_op != BOP_READ) begin
            abort_f <= 1'b1;
            cur_op  <= BOP_STOP;
            state   <= S_REQ;
          end else begin
            if (cur_op == BOP_WRITE) begin
              lane <= lane + 2'd1;
              if (lane == 2'd3) ptr <= ptr + 1'b1;
            end
            remain <= next_remain;
            cur_op <= (next_remain == 4'd0) ? BOP_STOP : (rd_mode ? BOP_READ : BOP_WRITE);
            state  <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_valid && !be_req_ready) |=> be_req_valid && $stable(be_op) && $stable(be_wdata)); // R12
  AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start != 2'b00) |=> $stable(act_q)); // R4
  AST_NACK_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nack != 2'b00) |-> $past(be_rsp_valid)); // R11
  AST_END_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((act_q ? q1_count : q0_count) == '0)); // R10
endmodule

// File: tb/i2c_cmd_seq_tb_top.sv
module i2c_cmd_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_queue = 0, be_req_ready = 0, be_rsp_valid = 0, be_rsp_nack = 0, rd_ready = 0;
  logic [31:0] ld_word = 0;
  logic [1:0] start = 0;
  logic [6:0] exec_len = 0;
  logic [7:0] be_rsp_data = 0;
  logic ld_ready, busy, be_req_valid, be_rd_last, rd_valid, ev_rd_done;
  logic [6:0] q0_count, q1_count;
  logic [1:0] q_ovf, be_op, ev_report, ev_nack;
  logic [7:0] be_wdata;
  logic [31:0] rd_data;
  logic [2:0] rd_level;

  int total = 0, bad = 0;
  bit fin = 0;
  logic [1:0] op_log [64];
  logic [7:0] dat_log [64];
  logic last_log [64];
  int log_n = 0, nack_idx = -1, pend = 0, viol = 0;
  int nrep0 = 0, nrep1 = 0, nrdd = 0, nnack0 = 0, nnack1 = 0;
  logic [7:0] rd_ctr = 8'hA0, rdat = 0;
  bit nack_now = 0, tgl = 0, hs = 0, wait_prev = 0;
  logic [1:0] op_prev = 0;
  logic [7:0] wd_prev = 0;

  always #10 clk = ~clk;

  i2c_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_queue(ld_queue),
    .ld_word(ld_word), .start(start), .exec_len(exec_len), .busy(busy), .q0_count(q0_count),
    .q1_count(q1_count), .q_ovf(q_ovf), .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_op(be_op), .be_wdata(be_wdata), .be_rd_last(be_rd_last), .be_rsp_valid(be_rsp_valid),
    .be_rsp_nack(be_rsp_nack), .be_rsp_data(be_rsp_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_level(rd_level), .ev_report(ev_report), .ev_rd_done(ev_rd_done),
    .ev_nack(ev_nack));

  // byte-engine responder and event monitor, all at the falling edge
  always @(negedge clk) begin
    be_rsp_valid = 0;
    if (rst_n) begin
      if (wait_prev && !(be_req_valid && be_op == op_prev && be_wdata == wd_prev)) viol++;
      if (hs) begin
        op_log[log_n] = op_prev; dat_log[log_n] = wd_prev; last_log[log_n] = be_rd_last;
        nack_now = (log_n == nack_idx);
        if (op_prev == 2'd2) begin rdat = rd_ctr; rd_ctr = rd_ctr + 1; end
        log_n++;
        pend = 2;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin be_rsp_valid = 1; be_rsp_nack = nack_now; be_rsp_data = rdat; end
      end
      if (ev_report[0]) nrep0++;
      if (ev_report[1]) nrep1++;
      if (ev_rd_done) nrdd++;
      if (ev_nack[0]) nnack0++;
      if (ev_nack[1]) nnack1++;
    end
    tgl = ~tgl;
    be_req_ready = tgl && pend == 0 && !be_rsp_valid && !hs;
    hs = be_req_valid && be_req_ready;
    wait_prev = be_req_valid && !be_req_ready;
    op_prev = be_op; wd_prev = be_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic q, input logic [31:0] w);
    @(negedge clk); ld_valid = 1; ld_queue = q; ld_word = w;
    @(negedge clk); ld_valid = 0;
  endtask

  task automatic run(input logic q, input logic [6:0] n);
    @(negedge clk); exec_len = n; start = q ? 2'b10 : 2'b01;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic chk_log(input string tag, input int i, input logic [1:0] op, input logic [7:0] d);
    chk({tag, " op"}, 32'(op_log[i]), 32'(op));
    if (op == 2'd0 || op == 2'd1) chk({tag, " data"}, 32'(dat_log[i]), 32'(d));
  endtask

  task automatic t_reset;
    chk("R1 q0_count", 32'(q0_count), 0);
    chk("R1 q1_count", 32'(q1_count), 0);
    chk("R1 busy/req/ovf", {busy, be_req_valid, q_ovf}, 0);
    chk("R1 rd_level", 32'(rd_level), 0);
    chk("R1 ld_ready", 32'(ld_ready), 1);
  endtask

  task automatic t_write;
    int b = log_n; int r = nrep0;
    load(0, 32'h0000_02A1); load(0, 32'h3322_1159); load(0, 32'hEEEE_5544); load(0, 32'h0000_0108);
    chk("R2 q0 count after loads", 32'(q0_count), 4);
    run(0, 4);
    chk("R6 request count", log_n - b, 7);
    chk_log("R5 start addr write", b, 2'd0, 8'h54);
    chk_log("R6 byte0", b + 1, 2'd1, 8'h11);
    chk_log("R6 byte1", b + 2, 2'd1, 8'h22);
    chk_log("R6 byte2", b + 3, 2'd1, 8'h33);
    chk_log("R6 byte3", b + 4, 2'd1, 8'h44);
    chk_log("R6 byte4", b + 5, 2'd1, 8'h55);
    chk_log("R6 stop", b + 6, 2'd3, 0);
    chk("R9 report after payload", nrep0 - r, 1);
    chk("R10 q0 cleared", 32'(q0_count), 0);
  endtask

  task automatic t_read;
    int b = log_n; int r = nrep1; int d = nrdd;
    rd_ctr = 8'hA0;
    load(1, 32'h0000_0501); load(1, 32'h0000_003A); load(1, 32'h0000_004A); load(1, 32'h0000_0008);
    run(1, 4);
    chk("R7 request count", log_n - b, 11);
    chk_log("R5 start addr read", b, 2'd0, 8'hA1);
    chk_log("R7 rd", b + 1, 2'd2, 0);
    chk("R7 last flag first", {31'd0, last_log[b + 1]}, 0);
    chk("R7 last flag final", {31'd0, last_log[b + 3]}, 1);
    chk_log("R7 stop", b + 4, 2'd3, 0);
    chk_log("R7 second start", b + 5, 2'd0, 8'hA1);
    chk("R7 last flag final 2", {31'd0, last_log[b + 9]}, 1);
    chk_log("R7 second stop", b + 10, 2'd3, 0);
    chk("R7 rd_done pulses", nrdd - d, 2);
    chk("R9 report without enable", nrep1 - r, 0);
    chk("R8 level", 32'(rd_level), 3);
    chk("R8 word0", rd_data, 32'hA2A1_A0A1); rd_ready = 1; @(negedge clk);
    chk("R8 word1", rd_data, 32'hA5A4_A3A1); @(negedge clk);
    chk("R8 word2 padded", rd_data, 32'h0000_00A6); @(negedge clk);
    rd_ready = 0;
    chk("R8 drained", 32'(rd_level), 0);
  endtask

  task automatic t_overflow;
    int b = log_n; int r = nrep1;
    for (int i = 0; i < 16; i++) load(1, (i % 2) ? 32'h0000_000F : 32'h0000_0008);
    load(1, 32'h0000_0108);
    chk("R3 count held at full", 32'(q1_count), 16);
    chk("R3 ovf flags", 32'(q_ovf), 2);
    run(1, 16);
    chk("R3 ovf cleared at start", 32'(q_ovf), 0);
    chk("R9 skipped opcodes no request", log_n - b, 0);
    chk("R3 dropped word not executed", nrep1 - r, 0);
    chk("R10 q1 cleared", 32'(q1_count), 0);
  endtask

  task automatic t_nack;
    int b = log_n; int r = nrep0; int n = nnack0;
    load(0, 32'h0000_02A1); load(0, 32'h0088_7729); load(0, 32'h0000_0108);
    nack_idx = log_n + 1;
    run(0, 3);
    nack_idx = -1;
    chk("R11 request count", log_n - b, 3);
    chk_log("R11 write nacked", b + 1, 2'd1, 8'h77);
    chk_log("R11 stop", b + 2, 2'd3, 0);
    chk("R11 nack pulse", nnack0 - n, 1);
    chk("R11 rest skipped", nrep0 - r, 0);
    chk("R11 count cleared", 32'(q0_count), 0);
  endtask

  task automatic t_busy;
    int b; int r = nrep1;
    load(1, 32'h0000_0108);
    load(0, 32'h0000_02A1); load(0, 32'h0302_01B9); load(0, 32'h0706_0504); load(0, 32'h0B0A_0908);
    b = log_n;
    @(negedge clk); exec_len = 4; start = 2'b01;
    @(negedge clk); start = 2'b10; ld_queue = 0;
    #1 chk("R2 ld_ready low for running queue", 32'(ld_ready), 0);
    ld_queue = 1;
    #1 chk("R2 ld_ready high for other queue", 32'(ld_ready), 1);
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    chk("R6 max payload requests", log_n - b, 13);
    chk_log("R6 last payload byte", b + 11, 2'd1, 8'h0B);
    chk("R4 q1 untouched by busy start", 32'(q1_count), 1);
    chk("R4 no report from q1", nrep1 - r, 0);
    @(negedge clk); exec_len = 1; start = 2'b11;
    @(negedge clk); start = 0;
    chk("R4 both bits ignored", 32'(busy), 0);
    chk("R4 q1 still loaded", 32'(q1_count), 1);
    run(1, 1);
    chk("R9 report on q1", nrep1 - r, 1);
    chk("R12 request held while not ready", viol, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_overflow();
    t_nack();
    t_busy();
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule